// File: doc/BRIEF.md
# Stacked Interrupt Status and Mask Unit

This block gathers interrupt events for a script-driven bus controller. The events come in two classes: bus-side events and DMA-side events. Each event arrives as a one-cycle pulse from logic outside the block. An enable register for each class masks every event individually. An event that survives its mask is stored as one level in a small per-class stack.

A global status register carries a pending summary bit for each class and drives the `irq` output. It also holds the abort flag, the signal-process flag and a mirror of the connected input. Software services an interrupt by reading the class's source register. Each read returns the oldest stored level and removes it. Software keeps reading until both summary bits are clear.

A script interrupt instruction loads its 32-bit immediate value into a vector register and raises the script-interrupt source bit. A software-reset write empties both stacks, zeroes the vector and clears the signal-process flag.

Each stack is a small state machine with three states: `STK_EMPTY`, `STK_PARTIAL` and `STK_FULL`. It takes these named transitions:
- *first arrival*: EMPTY to PARTIAL, or EMPTY to FULL when the depth is 1.
- *fill*: PARTIAL to FULL.
- *drain*: FULL to PARTIAL.
- *last pop*: PARTIAL or FULL to EMPTY.
- *flush*: any state to EMPTY.

A push and a pop in the same cycle, or a merge into a full stack, keep the current state.

Top module: `irq_stack_unit`

## Requirements
- R1: After reset, every register reads 0, both stacks are empty and `irq` is 0.
- R2: An event whose enable bit is 0 is neither stored nor reported. The summary bit stays 0 and the source register reads 0.
- R3: An enabled bus event sets status bit 1. A read of the bus source register (address 2) returns the stored bits and removes that level. Bus bits are: 7 phase mismatch, 6 function complete, 5 bus timeout, 4 selected, 3 gross error, 2 unexpected disconnect, 1 reset received, 0 parity.
- R4: An enabled DMA event sets status bit 0. A read of the DMA source register (address 3) returns and removes it. DMA bits are: 5 bus fault, 4 aborted, 3 single step, 2 script interrupt, 1 watchdog, 0 illegal instruction.
- R5: Events that arrive in the same cycle form one level. Levels arriving in different cycles are returned oldest first, up to DEPTH (default 2) levels. An event arriving when the stack is full is ORed into the newest level. The summary bit stays 1 until the last level is read.
- R6: A source read and a new event in the same cycle return the current oldest level and store the new event.
- R7: A `script_int` pulse with DMA enable bit 2 set loads `script_vec` into the vector register (address 5) and sets DMA bit 2. With that enable bit clear, neither happens. The `dma_evt` bit 2 input is ignored.
- R8: While `wdt_period` is 0, watchdog events (DMA bit 1) are discarded.
- R9: While `tmo_disable` is 1, bus-timeout events (bus bit 5) are discarded.
- R10: In the status register (address 4):
  - bits 7 (abort) and 5 (signal process) read back the value last written;
  - bit 3 mirrors `connected`;
  - bit 6 and the reserved bits 4 and 2 read 0;
  - bits 1 and 0 ignore writes.
- R11: Writing status bit 6 as 1 empties both stacks and zeroes the vector and the signal-process flag. Events in that same cycle are dropped. The enables and the abort flag are kept.
- R12: `irq` is 1 exactly when status bit 1 or bit 0 is 1.
- R13: DMA enable bits 7 and 6 are reserved. They always read 0 and never pass an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scsi_evt | input | 8 | Bus-side event pulses |
| dma_evt | input | 8 | DMA-side event pulses (bit 2 unused) |
| script_int | input | 1 | Script interrupt instruction pulse |
| script_vec | input | 32 | Immediate value of the script interrupt |
| tmo_disable | input | 1 | Suppresses bus-timeout events |
| wdt_period | input | 8 | Watchdog period; 0 disables watchdog events |
| connected | input | 1 | Connected state shown in status bit 3 |
| reg_addr | input | 3 | Register address: 0 bus enable, 1 DMA enable, 2 bus source, 3 DMA source, 4 status, 5 vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops sources) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a source-register pop and the arrival of a new event in the same stack. A software-reset write can also coincide with an incoming event. The bench provokes the first by asserting `reg_rd` on the bus source address while pulsing a new event on `scsi_evt`. It judges the outcome by the returned word, which must be the older level, and by the following read, which must return the new event. The second is provoked by pulsing an event together with the reset write, then confirming that the status register shows no pending bit.

// File: rtl/irq_stack_pkg.sv
package irq_stack_pkg;
    localparam int EVT_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_SCSI_EN  = 3'd0;
    localparam logic [ADDR_W-1:0] A_DMA_EN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_SCSI_SRC = 3'd2;
    localparam logic [ADDR_W-1:0] A_DMA_SRC  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS   = 3'd4;
    localparam logic [ADDR_W-1:0] A_VECTOR   = 3'd5;

    localparam int B_TIMEOUT  = 5;
    localparam int B_WATCHDOG = 1;
    localparam int B_SCRIPT   = 2;
    localparam int ST_ABORT   = 7;
    localparam int ST_SWRST   = 6;
    localparam int ST_SIGP    = 5;
    localparam int ST_CONN    = 3;
    localparam int ST_SIP     = 1;
    localparam int ST_DIP     = 0;

    localparam logic [EVT_W-1:0] DMA_IMPL_MASK = 8'h3F;

    typedef enum logic [1:0] {
        STK_EMPTY,
        STK_PARTIAL,
        STK_FULL
    } stk_state_t;
endpackage

// File: rtl/irq_event_gate.sv
module irq_event_gate
    import irq_stack_pkg::*;
#(
    parameter int WDT_W = 8
) (
    input  logic [EVT_W-1:0] scsi_evt,
    input  logic [EVT_W-1:0] dma_evt,
    input  logic             script_fire,
    input  logic [EVT_W-1:0] scsi_en,
    input  logic [EVT_W-1:0] dma_en,
    input  logic             tmo_disable,
    input  logic [WDT_W-1:0] wdt_period,
    input  logic             flush,
    output logic [EVT_W-1:0] scsi_push,
    output logic [EVT_W-1:0] dma_push
);
    logic [EVT_W-1:0] scsi_qual;
    logic [EVT_W-1:0] dma_raw;
    logic [EVT_W-1:0] dma_qual;

    always_comb begin
        scsi_qual = scsi_evt;
        if (tmo_disable) begin
            scsi_qual[B_TIMEOUT] = 1'b0;
        end
        dma_raw = dma_evt & DMA_IMPL_MASK;
        dma_raw[B_SCRIPT] = script_fire;
        dma_qual = dma_raw;
        if (wdt_period == '0) begin
            dma_qual[B_WATCHDOG] = 1'b0;
        end
        scsi_push = flush ? '0 : (scsi_qual & scsi_en);
        dma_push  = flush ? '0 : (dma_qual & dma_en & DMA_IMPL_MASK);
    end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_stack_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] push_vec,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] head,
    output logic         nonempty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    stk_state_t   state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n, cnt_p;
    logic [W-1:0]  ent_q [DEPTH];
    logic [W-1:0]  ent_n [DEPTH];
    logic          push_any, pop_eff;

    assign push_any = |push_vec;
    assign pop_eff  = pop && (state_q != STK_EMPTY);

    // storage and next-state computation
    always_comb begin
        ent_n = ent_q;
        cnt_p = cnt_q;
        if (pop_eff) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                ent_n[i] = ent_q[i+1];
            end
            ent_n[DEPTH-1] = '0;
            cnt_p = cnt_q - 1'b1;
        end
        cnt_n = cnt_p;
        if (push_any) begin
            if (cnt_p < CNT_FULL) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == cnt_p) begin
                        ent_n[i] = push_vec;
                    end
                end
                cnt_n = cnt_p + 1'b1;
            end else begin
                ent_n[DEPTH-1] = ent_n[DEPTH-1] | push_vec;
            end
        end
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_n[i] = '0;
            end
            cnt_n = '0;
        end
        if (cnt_n == '0) begin
            state_n = STK_EMPTY;
        end else if (cnt_n == CNT_FULL) begin
            state_n = STK_FULL;
        end else begin
            state_n = STK_PARTIAL;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STK_EMPTY;
            cnt_q   <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            ent_q   <= ent_n;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            STK_EMPTY: begin
                nonempty = 1'b0;
                head     = '0;
            end
            STK_PARTIAL, STK_FULL: begin
                nonempty = 1'b1;
                head     = ent_q[0];
            end
            default: begin
                nonempty = 1'b0;
                head     = '0;
            end
        endcase
    end

    // R5
    full_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == STK_FULL && push_any && !pop && !flush) |=> (state_q == STK_FULL));

    // R5
    state_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == STK_EMPTY) == (cnt_q == '0));

    // R6
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != STK_EMPTY && pop && push_any && !flush) |=> $stable(cnt_q));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !nonempty);
endmodule

// File: rtl/irq_stack_unit.sv
module irq_stack_unit
    import irq_stack_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int VEC_W = 32,
    parameter int WDT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          scsi_evt,
    input  logic [7:0]          dma_evt,
    input  logic                script_int,
    input  logic [VEC_W-1:0]    script_vec,
    input  logic                tmo_disable,
    input  logic [WDT_W-1:0]    wdt_period,
    input  logic                connected,
    input  logic [2:0]          reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [7:0]          reg_wdata,
    output logic [VEC_W-1:0]    reg_rdata,
    output logic                irq
);
    logic [EVT_W-1:0] scsi_en_q, dma_en_q;
    logic             abort_q, sigp_q;
    logic [VEC_W-1:0] vec_q;
    logic             soft_rst, wr_status, vec_load;
    logic             pop_scsi, pop_dma;
    logic [EVT_W-1:0] scsi_push, dma_push;
    logic [EVT_W-1:0] scsi_head, dma_head;
    logic             sip, dip;
    logic [7:0]       status_word;

    assign wr_status = reg_wr && (reg_addr == A_STATUS);
    assign soft_rst  = wr_status && reg_wdata[ST_SWRST];
    assign vec_load  = script_int && dma_en_q[B_SCRIPT] && !soft_rst;
    assign pop_scsi  = reg_rd && (reg_addr == A_SCSI_SRC);
    assign pop_dma   = reg_rd && (reg_addr == A_DMA_SRC);

    irq_event_gate #(.WDT_W(WDT_W)) u_gate (
        .scsi_evt    (scsi_evt),
        .dma_evt     (dma_evt),
        .script_fire (script_int),
        .scsi_en     (scsi_en_q),
        .dma_en      (dma_en_q),
        .tmo_disable (tmo_disable),
        .wdt_period  (wdt_period),
        .flush       (soft_rst),
        .scsi_push   (scsi_push),
        .dma_push    (dma_push)
    );

    irq_level_stack #(.W(EVT_W), .DEPTH(DEPTH)) u_scsi_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_vec (scsi_push),
        .pop      (pop_scsi),
        .flush    (soft_rst),
        .head     (scsi_head),
        .nonempty (sip)
    );

    irq_level_stack #(.W(EVT_W), .DEPTH(DEPTH)) u_dma_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_vec (dma_push),
        .pop      (pop_dma),
        .flush    (soft_rst),
        .head     (dma_head),
        .nonempty (dip)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scsi_en_q <= '0;
            dma_en_q  <= '0;
            abort_q   <= 1'b0;
            sigp_q    <= 1'b0;
            vec_q     <= '0;
        end else begin
            if (reg_wr && reg_addr == A_SCSI_EN) begin
                scsi_en_q <= reg_wdata;
            end
            if (reg_wr && reg_addr == A_DMA_EN) begin
                dma_en_q <= reg_wdata & DMA_IMPL_MASK;
            end
            if (wr_status) begin
                abort_q <= reg_wdata[ST_ABORT];
                sigp_q  <= reg_wdata[ST_SIGP] && !soft_rst;
            end
            if (soft_rst) begin
                vec_q <= '0;
            end else if (vec_load) begin
                vec_q <= script_vec;
            end
        end
    end

    always_comb begin
        status_word = '0;
        status_word[ST_ABORT] = abort_q;
        status_word[ST_SIGP]  = sigp_q;
        status_word[ST_CONN]  = connected;
        status_word[ST_SIP]   = sip;
        status_word[ST_DIP]   = dip;
    end

    always_comb begin
        case (reg_addr)
            A_SCSI_EN:  reg_rdata = VEC_W'(scsi_en_q);
            A_DMA_EN:   reg_rdata = VEC_W'(dma_en_q);
            A_SCSI_SRC: reg_rdata = VEC_W'(scsi_head);
            A_DMA_SRC:  reg_rdata = VEC_W'(dma_head);
            A_STATUS:   reg_rdata = VEC_W'(status_word);
            A_VECTOR:   reg_rdata = vec_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = sip | dip;

    // R7
    vector_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |=> (vec_q == $past(script_vec)));

    // R11
    soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (vec_q == '0 && !sigp_q && !sip && !dip));

    // R13
    dma_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en_q[7:6] == 2'b00);

    // R2
    masked_scsi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sip && scsi_en_q == '0 && !reg_wr) |=> !sip);
endmodule

// File: tb/irq_stack_unit_bench.sv
`timescale 1ns/1ps
module irq_stack_unit_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  scsi_evt = 0, dma_evt = 0;
    logic        script_int = 0;
    logic [31:0] script_vec = 0;
    logic        tmo_disable = 0;
    logic [7:0]  wdt_period = 8'd4;
    logic        connected = 0;
    logic [2:0]  reg_addr = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    irq_stack_unit u_irq_stack_unit (
        .clk(clk), .rst_n(rst_n), .scsi_evt(scsi_evt), .dma_evt(dma_evt),
        .script_int(script_int), .script_vec(script_vec),
        .tmo_disable(tmo_disable), .wdt_period(wdt_period),
        .connected(connected), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    // monitor: pops expected read data and compares
    always @(negedge clk) begin
        #1;
        if (reg_rd && q_exp.size() > 0) begin
            logic [31:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_checks++;
            if (reg_rdata !== e) begin
                n_fail++;
                $display("FAIL %s addr %0d: got %h expected %h", t, reg_addr, reg_rdata, e);
            end
        end
    end

    task automatic chk_irq(input logic exp, input string tag);
        n_checks++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s irq: got %b expected %b", tag, irq, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        q_exp.push_back(e); q_tag.push_back(tag);
        @(posedge clk); #1;
        reg_rd = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic pulse(input logic [7:0] s, input logic [7:0] d);
        @(negedge clk);
        scsi_evt = s; dma_evt = d;
        @(posedge clk); #1;
        scsi_evt = 0; dma_evt = 0;
    endtask

    task automatic script(input logic [31:0] v);
        @(negedge clk);
        script_int = 1; script_vec = v;
        @(posedge clk); #1;
        script_int = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 6; a++) rd(3'(a), 32'h0, "R1");
        chk_irq(0, "R1");
        // R13 reserved DMA enable bits
        wr(3'd1, 8'hFF);
        rd(3'd1, 32'h3F, "R13");
        pulse(8'h00, 8'hC0);
        rd(3'd4, 32'h00, "R13");
        // R2 masked bus event
        pulse(8'h08, 8'h00);
        rd(3'd4, 32'h00, "R2");
        rd(3'd2, 32'h00, "R2");
        chk_irq(0, "R2");
        // R3 bus event
        wr(3'd0, 8'hFF);
        pulse(8'h08, 8'h00);
        chk_irq(1, "R12");
        rd(3'd4, 32'h02, "R3");
        rd(3'd2, 32'h08, "R3");
        rd(3'd4, 32'h00, "R3");
        chk_irq(0, "R12");
        // R5 stacking and merging
        pulse(8'h01, 8'h00);
        pulse(8'h04, 8'h00);
        pulse(8'h80, 8'h00);
        rd(3'd2, 32'h01, "R5");
        rd(3'd4, 32'h02, "R5");
        rd(3'd2, 32'h84, "R5");
        rd(3'd4, 32'h00, "R5");
        pulse(8'h11, 8'h00);
        rd(3'd2, 32'h11, "R5");
        rd(3'd2, 32'h00, "R5");
        // R4 DMA event
        pulse(8'h00, 8'h20);
        rd(3'd4, 32'h01, "R4");
        chk_irq(1, "R12");
        rd(3'd3, 32'h20, "R4");
        rd(3'd4, 32'h00, "R4");
        // R8 watchdog disabled by zero period
        wdt_period = 0;
        pulse(8'h00, 8'h02);
        rd(3'd4, 32'h00, "R8");
        wdt_period = 8'd7;
        pulse(8'h00, 8'h02);
        rd(3'd3, 32'h02, "R8");
        // R9 bus-timeout disable
        tmo_disable = 1;
        pulse(8'h20, 8'h00);
        rd(3'd4, 32'h00, "R9");
        tmo_disable = 0;
        pulse(8'h20, 8'h00);
        rd(3'd2, 32'h20, "R9");
        // R7 script interrupt
        script(32'hDEADBEEF);
        rd(3'd5, 32'hDEADBEEF, "R7");
        rd(3'd3, 32'h04, "R7");
        pulse(8'h00, 8'h04);
        rd(3'd3, 32'h00, "R7");
        wr(3'd1, 8'h3B);
        script(32'h12345678);
        rd(3'd5, 32'hDEADBEEF, "R7");
        rd(3'd3, 32'h00, "R7");
        wr(3'd1, 8'h3F);
        // R6 pop and push in one cycle
        pulse(8'h40, 8'h00);
        @(negedge clk);
        reg_addr = 3'd2; reg_rd = 1; scsi_evt = 8'h02;
        q_exp.push_back(32'h40); q_tag.push_back("R6");
        @(posedge clk); #1;
        reg_rd = 0; scsi_evt = 0;
        rd(3'd2, 32'h02, "R6");
        rd(3'd4, 32'h00, "R6");
        // R10 status bits
        connected = 1;
        wr(3'd4, 8'hBF);
        rd(3'd4, 32'hA8, "R10");
        wr(3'd4, 8'h00);
        rd(3'd4, 32'h08, "R10");
        connected = 0;
        // R11 software reset
        wr(3'd4, 8'h20);
        pulse(8'h01, 8'h20);
        script(32'hCAFE0001);
        wr(3'd4, 8'hC0);
        rd(3'd4, 32'h80, "R11");
        rd(3'd5, 32'h0, "R11");
        rd(3'd2, 32'h0, "R11");
        rd(3'd3, 32'h0, "R11");
        rd(3'd0, 32'hFF, "R11");
        chk_irq(0, "R11");
        @(negedge clk);
        reg_addr = 3'd4; reg_wdata = 8'h40; reg_wr = 1; scsi_evt = 8'h08;
        @(posedge clk); #1;
        reg_wr = 0; scsi_evt = 0;
        rd(3'd4, 32'h00, "R11");
        chk_irq(0, "R11");
        repeat (2) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule